// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 14-bit logical word address into a 15-bit physical word address. Both address spaces are cut into 2048-word pages. Eight user page registers and two monitor page registers describe where each logical page lives in real memory. They also say whether the page is present and whether it may be written.

In user mode every reference goes through the user registers. In monitor mode a reference is absolute by default. A per-reference flag sends it through the user registers instead. Without that flag, references into the top 4096 words of logical space go through the two monitor registers.

A reference that reaches a page with no assignment, or that writes a read-only page, is not issued as a physical access. The block reports it as a trap instead, with a cause code and the logical page number. The result of each request is registered and appears one cycle after the request.

Top module: `xlat_unit`

## Requirements
- R1: After reset all ten page registers read as unassigned (all ones), so every mapped reference traps with cause 1. While reset is held, `rsp_valid` is 0.
- R2: Each page register is 6 bits: bit 5 marks the page unassigned, bit 4 marks it read-only, and bits 3..0 give the real page. A user-mode reference to logical page `a[13:11]` produces the physical address `{real page, a[10:0]}`. For example, logical 024654 (octal) with user register 5 set to 011 (octal) gives 044654 (octal).
- R3: A monitor-mode reference without the user-map flag to logical pages 0..5 is absolute. The physical address is the logical address with a 0 prepended, and it never traps.
- R4: A monitor-mode reference with the user-map flag set uses the user registers on every page, including pages 6 and 7.
- R5: A monitor-mode reference without the flag to logical page 6 uses monitor register 0, and one to page 7 uses monitor register 1.
- R6: Any mapped reference, read or write, whose register has bit 5 set traps with cause 1. In that case `rsp_access` is 0 and `rsp_paddr` is 0. Bit 5 takes precedence over bit 4.
- R7: A write through a register that has bit 4 set and bit 5 clear traps with cause 2. A read through the same register is a normal access. Cause 0 means no trap.
- R8: Every result carries the logical page number of its request on `rsp_page`.
- R9: A register write with `wr_sel` 0..7 sets that user register, and 8..9 sets monitor registers 0..1. Selector values 10..15 change nothing. A write takes effect for requests made in the following cycle; a request made in the same cycle as the write still sees the old value.
- R10: The result for a request appears exactly one cycle later, with `rsp_valid` set. In a cycle with no request, the next cycle shows `rsp_valid`, `rsp_access` and `rsp_trap` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Page register write strobe |
| wr_sel | input | 4 | Register selector: 0..7 user, 8..9 monitor |
| wr_data | input | 6 | Register value: unassigned, read-only, real page |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 14 | Logical word address |
| req_monitor | input | 1 | 1 for monitor mode, 0 for user mode |
| req_use_umap | input | 1 | In monitor mode, force the user registers |
| req_write | input | 1 | Reference is a store |
| rsp_valid | output | 1 | Result present, one cycle after the request |
| rsp_access | output | 1 | Physical access may be issued |
| rsp_trap | output | 1 | Reference violated its page |
| rsp_cause | output | 2 | 0 none, 1 unassigned, 2 read-only write |
| rsp_page | output | 3 | Logical page number of the request |
| rsp_paddr | output | 15 | Physical word address, 0 on a trap |

## Verification
The bench builds the block with its default sizes: eight user pages, two monitor pages and 4-bit real page numbers. At these sizes every logical page can be swept under all three mode paths, both access types and the first, middle and last offset of a page. That sweep covers every page register, the boundary between absolute and monitor-mapped space at page 6, and the precedence of unassigned over read-only. The out-of-range selector values and the write-versus-request timing in the same cycle are also within reach at these sizes.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    parameter int ADDR_W    = 14;
    parameter int OFF_W     = 11;
    parameter int PADDR_W   = 15;
    parameter int MON_PAGES = 2;

    localparam int PAGE_W   = ADDR_W - OFF_W;
    localparam int NPAGES   = 1 << PAGE_W;
    localparam int RPAGE_W  = PADDR_W - OFF_W;
    localparam int ENTRY_W  = RPAGE_W + 2;
    localparam int UA_BIT   = ENTRY_W - 1;
    localparam int RO_BIT   = ENTRY_W - 2;
    localparam int NREGS    = NPAGES + MON_PAGES;
    localparam int SEL_W    = $clog2(NREGS);
    localparam int MON_BASE = NPAGES - MON_PAGES;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_UNASSIGNED = 2'd1,
        CAUSE_READONLY   = 2'd2
    } cause_e;

    typedef struct packed {
        logic               valid;
        logic               access;
        logic               trap;
        cause_e             cause;
        logic [PAGE_W-1:0]  page;
        logic [PADDR_W-1:0] paddr;
    } rsp_t;
endpackage

// File: rtl/xlat_mapregs.sv
`timescale 1ns/1ps
module xlat_mapregs
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  entry_t           wr_data,
    output entry_t           user_map [NPAGES],
    output entry_t           mon_map  [MON_PAGES]
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NREGS - 1);

    entry_t regs_d [NREGS];
    entry_t regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_en && (wr_sel <= LAST_SEL)) begin
            for (int i = 0; i < NREGS; i++) begin
                if (wr_sel == SEL_W'(i)) begin
                    regs_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (!rst_n) begin
                regs_q[i] <= '1;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar g = 0; g < NPAGES; g++) begin : g_user
        assign user_map[g] = regs_q[g];
    end
    for (genvar m = 0; m < MON_PAGES; m++) begin : g_mon
        assign mon_map[m] = regs_q[NPAGES + m];
    end
endmodule

// File: rtl/xlat_lookup.sv
`timescale 1ns/1ps
module xlat_lookup
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               monitor,
    input  logic               use_umap,
    input  logic               write,
    input  entry_t             user_map [NPAGES],
    input  entry_t             mon_map  [MON_PAGES],
    output logic [PADDR_W-1:0] paddr,
    output logic               trap,
    output cause_e             cause
);
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;
    logic              mapped;
    entry_t            ent;

    assign page = addr[ADDR_W-1:OFF_W];
    assign off  = addr[OFF_W-1:0];

    always_comb begin
        mapped = 1'b0;
        ent    = '0;
        if (!monitor || use_umap) begin
            mapped = 1'b1;
            ent    = user_map[page];
        end else begin
            for (int i = 0; i < MON_PAGES; i++) begin
                if (page == PAGE_W'(MON_BASE + i)) begin
                    mapped = 1'b1;
                    ent    = mon_map[i];
                end
            end
        end

        trap  = 1'b0;
        cause = CAUSE_NONE;
        paddr = PADDR_W'(addr);
        if (mapped) begin
            paddr = {ent[RPAGE_W-1:0], off};
            if (ent[UA_BIT]) begin
                trap  = 1'b1;
                cause = CAUSE_UNASSIGNED;
            end else if (ent[RO_BIT] && write) begin
                trap  = 1'b1;
                cause = CAUSE_READONLY;
            end
        end
        if (trap) begin
            paddr = '0;
        end
    end
endmodule

// File: rtl/xlat_unit.sv
`timescale 1ns/1ps
module xlat_unit
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_monitor,
    input  logic               req_use_umap,
    input  logic               req_write,
    output logic               rsp_valid,
    output logic               rsp_access,
    output logic               rsp_trap,
    output logic [1:0]         rsp_cause,
    output logic [PAGE_W-1:0]  rsp_page,
    output logic [PADDR_W-1:0] rsp_paddr
);
    entry_t             user_map [NPAGES];
    entry_t             mon_map  [MON_PAGES];
    logic [PADDR_W-1:0] paddr_c;
    logic               trap_c;
    cause_e             cause_c;
    rsp_t               rsp_d;
    rsp_t               rsp_q;

    xlat_mapregs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .user_map (user_map),
        .mon_map  (mon_map)
    );

    xlat_lookup u_look (
        .addr     (req_addr),
        .monitor  (req_monitor),
        .use_umap (req_use_umap),
        .write    (req_write),
        .user_map (user_map),
        .mon_map  (mon_map),
        .paddr    (paddr_c),
        .trap     (trap_c),
        .cause    (cause_c)
    );

    always_comb begin
        rsp_d        = '0;
        rsp_d.cause  = CAUSE_NONE;
        if (req_valid) begin
            rsp_d.valid  = 1'b1;
            rsp_d.trap   = trap_c;
            rsp_d.access = !trap_c;
            rsp_d.cause  = cause_c;
            rsp_d.page   = req_addr[ADDR_W-1:OFF_W];
            rsp_d.paddr  = paddr_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_access = rsp_q.access;
    assign rsp_trap   = rsp_q.trap;
    assign rsp_cause  = rsp_q.cause;
    assign rsp_page   = rsp_q.page;
    assign rsp_paddr  = rsp_q.paddr;
endmodule

// File: rtl/xlat_chk.sv
`timescale 1ns/1ps
module xlat_chk
    import xlat_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               req_monitor,
    input logic               req_use_umap,
    input logic               req_write,
    input logic               rsp_valid,
    input logic               rsp_access,
    input logic               rsp_trap,
    input logic [1:0]         rsp_cause,
    input logic [PAGE_W-1:0]  rsp_page,
    input logic [PADDR_W-1:0] rsp_paddr
);
    // R10
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_access && !rsp_trap));

    // R6
    trap_blocks_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> (!rsp_access && rsp_paddr == '0 && rsp_cause != 2'd0));

    // R3
    absolute_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_monitor && !req_use_umap
         && (req_addr[ADDR_W-1:OFF_W] < PAGE_W'(MON_BASE)))
        |=> (!rsp_trap && rsp_paddr == PADDR_W'($past(req_addr))));

    // R7
    read_never_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rsp_cause != 2'd2));

    // R8
    page_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_page == $past(req_addr[ADDR_W-1:OFF_W])));
endmodule

bind xlat_unit xlat_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_monitor  (req_monitor),
    .req_use_umap (req_use_umap),
    .req_write    (req_write),
    .rsp_valid    (rsp_valid),
    .rsp_access   (rsp_access),
    .rsp_trap     (rsp_trap),
    .rsp_cause    (rsp_cause),
    .rsp_page     (rsp_page),
    .rsp_paddr    (rsp_paddr)
);

// File: tb/tb_xlat_unit.sv
`timescale 1ns/1ps
module tb_xlat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [5:0]  wr_data = '0;
    logic        req_valid = 1'b0;
    logic [13:0] req_addr = '0;
    logic        req_monitor = 1'b0;
    logic        req_use_umap = 1'b0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_access, rsp_trap;
    logic [1:0]  rsp_cause;
    logic [2:0]  rsp_page;
    logic [14:0] rsp_paddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [5:0] umap [8];
    logic [5:0] mmap [2];

    always #2.5 clk = ~clk;

    xlat_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .req_monitor(req_monitor),
        .req_use_umap(req_use_umap), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_access(rsp_access), .rsp_trap(rsp_trap),
        .rsp_cause(rsp_cause), .rsp_page(rsp_page), .rsp_paddr(rsp_paddr)
    );

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(logic [3:0] sel, logic [5:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (sel < 8) umap[sel[2:0]] = val;
        else if (sel < 10) mmap[sel - 4'd8] = val;
    endtask

    task automatic exp_of(logic [13:0] a, logic mon, logic flag, logic w,
                          output logic trap, output logic [1:0] cause,
                          output logic [14:0] pa, output string tag);
        logic [2:0] pg;
        logic [5:0] e;
        logic mapped;
        pg = a[13:11];
        mapped = 1'b1;
        e = '0;
        if (!mon) begin e = umap[pg]; tag = "R2"; end
        else if (flag) begin e = umap[pg]; tag = "R4"; end
        else if (pg >= 6) begin e = mmap[pg - 3'd6]; tag = "R5"; end
        else begin mapped = 1'b0; tag = "R3"; end
        trap = 1'b0; cause = 2'd0; pa = {1'b0, a};
        if (mapped) begin
            pa = {e[3:0], a[10:0]};
            if (e[5]) begin trap = 1'b1; cause = 2'd1; tag = {tag, "/R6"}; end
            else if (e[4] && w) begin trap = 1'b1; cause = 2'd2; tag = {tag, "/R7"}; end
        end
        if (trap) pa = '0;
    endtask

    task automatic do_req(logic [13:0] a, logic mon, logic flag, logic w);
        logic t; logic [1:0] c; logic [14:0] pa; string tag;
        exp_of(a, mon, flag, w, t, c, pa, tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_monitor = mon;
        req_use_umap = flag; req_write = w;
        @(posedge clk);
        #1 req_valid = 1'b0;
        cmp("R10 valid", 32'(rsp_valid), 32'd1);
        cmp({tag, " trap"}, 32'(rsp_trap), 32'(t));
        cmp({tag, " access"}, 32'(rsp_access), 32'(!t));
        cmp({tag, " cause"}, 32'(rsp_cause), 32'(c));
        cmp({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
        cmp("R8 page", 32'(rsp_page), 32'(a[13:11]));
    endtask

    task automatic sweep();
        logic [10:0] offs [3];
        offs[0] = 11'h000; offs[1] = 11'h2A5; offs[2] = 11'h7FF;
        for (int p = 0; p < 8; p++)
            for (int m = 0; m < 3; m++)
                for (int w = 0; w < 2; w++)
                    for (int o = 0; o < 3; o++)
                        do_req({3'(p), offs[o]}, m != 0, m == 2, w != 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) umap[i] = 6'h3F;
        for (int i = 0; i < 2; i++) mmap[i] = 6'h3F;
        repeat (3) @(posedge clk);
        #1 cmp("R1 reset valid", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        // R1: everything unassigned after reset
        sweep();

        // R10: idle cycle gives quiet outputs
        @(negedge clk);
        @(posedge clk);
        #1 cmp("R10 idle", 32'({rsp_valid, rsp_access, rsp_trap}), 32'd0);

        // R2: worked example, register 5 = 011 octal
        write_reg(4'd5, 6'o11);
        do_req(14'o24654, 1'b0, 1'b0, 1'b0);
        cmp("R2 example", 32'(rsp_paddr), 32'o44654);

        // R9: program all registers
        write_reg(4'd0, 6'h25);
        write_reg(4'd1, 6'h13);
        write_reg(4'd2, 6'h07);
        write_reg(4'd3, 6'h0C);
        write_reg(4'd4, 6'h1F);
        write_reg(4'd6, 6'h00);
        write_reg(4'd7, 6'h30);
        write_reg(4'd8, 6'h1E);
        write_reg(4'd9, 6'h0F);
        sweep();

        // R9: out-of-range selectors leave every register alone
        for (int s = 10; s < 16; s++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 4'(s); wr_data = 6'h02;
            @(posedge clk);
            #1 wr_en = 1'b0;
        end
        sweep();

        // R9: write and request in the same cycle see the old value
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd2; wr_data = 6'h0A;
        req_valid = 1'b1; req_addr = {3'd2, 11'h123}; req_monitor = 1'b0;
        req_use_umap = 1'b0; req_write = 1'b0;
        @(posedge clk);
        #1 wr_en = 1'b0; req_valid = 1'b0;
        cmp("R9 old value", 32'(rsp_paddr), 32'({4'h7, 11'h123}));
        umap[2] = 6'h0A;
        do_req({3'd2, 11'h123}, 1'b0, 1'b0, 1'b0);
        cmp("R9 new value", 32'(rsp_paddr), 32'({4'hA, 11'h123}));

        // R9: second register pattern
        for (int i = 0; i < 8; i++) write_reg(4'(i), 6'((i * 7 + 3) & 15) | (i[0] ? 6'h10 : 6'h00));
        write_reg(4'd8, 6'h21);
        write_reg(4'd9, 6'h14);
        sweep();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule